// File: doc/BRIEF.md
# Serial Receiver with Two-Word Error-Tagged Queue

This block receives asynchronous serial frames on a single input line and makes them available to a processor through a small queue. The line is brought into the clock domain through a two-stage synchronizer. A frame engine watches it at sixteen sample strobes per bit. The engine checks that a start bit is real, collects the data bits least significant first, checks an optional parity bit and tests the first stop bit. It then hands the finished word, with its own error bits, to a two-entry queue.

The processor sees the oldest queued word together with its frame-error and parity-error bits. It sees a flag that is high while anything is queued, and a sticky overrun flag. It reads the status first and then pulses a pop strobe to take the word. Both queue entries can be full while a third frame is still being collected in the engine. If that third frame finishes before a slot is free, it is dropped and the overrun flag is raised. Clearing the enable throws away the queue, the overrun flag and any frame in progress in a single cycle.

Top module: `serrx_top`

## Requirements
- R1: After reset, `rx_done`, `st_overrun`, `st_frame_err`, `st_parity_err` and `rx_data` are all 0.
- R2: A frame is a 0 start bit, then N data bits sent least significant first, then an optional parity bit, then a 1 stop bit. N is set by `cfg_len`: 0→5, 1→6, 2→7, 3→8, and any value of 4 or more gives 9. The word appears right-aligned in `rx_data`, and its unused upper bits read 0.
- R3: A falling edge on the line is treated as a start bit only if the line is still 0 on the 8th sample strobe, counting the strobe that saw the edge as the 1st. If the line is 1 there, the receiver returns to idle and queues nothing.
- R4: `rx_done` is high exactly while at least one word is queued. A one-cycle `rd_pop` removes the oldest word. `rx_done` falls in the cycle after the pop that empties the queue.
- R5: The queue holds two words in arrival order. A third frame can be collected in full while both entries are occupied.
- R6: `st_frame_err` of an entry is 1 when its first stop bit was sampled as 0. A second stop bit is never examined.
- R7: `cfg_parity` selects the parity rule: 00 or 01 means no parity bit, 10 means even, 11 means odd. `st_parity_err` of an entry is 1 when the data bits plus the parity bit break the selected rule. It is always 0 when parity is off.
- R8: The error bits belong to their word. The status outputs always describe the entry that the next pop removes.
- R9: If a word completes while both entries are full and no pop happens in that cycle, the word is lost and `st_overrun` becomes 1. The queued words are not changed. `st_overrun` is cleared by the next pop.
- R10: While `cfg_enable` is 0 the receiver is held idle. The cycle after it goes low, `rx_done` and `st_overrun` are 0, and no word from a frame that was in progress is ever queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | Sample strobe, sixteen per bit period |
| rx_line | input | 1 | Asynchronous serial input, idles at 1 |
| cfg_enable | input | 1 | Receiver enable; low discards everything |
| cfg_len | input | 3 | Data length code (R2) |
| cfg_parity | input | 2 | Parity rule code (R7) |
| rd_pop | input | 1 | One-cycle strobe removing the head word |
| rx_done | output | 1 | At least one word queued |
| rx_data | output | 9 | Head word, zero when the queue is empty |
| st_frame_err | output | 1 | Frame error of the head word |
| st_parity_err | output | 1 | Parity error of the head word |
| st_overrun | output | 1 | A completed word was dropped (sticky until pop) |

## Verification
The assertions assume that `cfg_len` and `cfg_parity` change only while the line is idle between frames. They also assume that `rd_pop` is a single-cycle strobe and that `os_tick` is a one-cycle pulse. The stimulus changes configuration only after a frame has been fully sent and the line has been idle for two bit times. It generates the strobe from a free-running divider and drives the pop strobe for exactly one clock. It also holds every bit for exactly sixteen strobes, so the centre sample never falls near a bit edge, except for the deliberate glitch and short-stop cases.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    localparam int MAX_BITS = 9;
    localparam int OS_RATE  = 16;
    localparam int MID_TICK = OS_RATE / 2;
    localparam int CNT_W    = $clog2(OS_RATE);
    localparam int IDX_W    = $clog2(MAX_BITS + 1);
    localparam int Q_DEPTH  = 2;

    typedef logic [MAX_BITS-1:0] word_t;

    typedef struct packed {
        word_t data;
        logic  ferr;
        logic  perr;
    } entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // Index of the last data bit for a length code.
    function automatic logic [IDX_W-1:0] last_index(input logic [2:0] code);
        if (code > 3'd4)
            return IDX_W'(MAX_BITS - 1);
        else
            return IDX_W'(code) + IDX_W'(4);
    endfunction

    // High when data plus parity bit violate the rule (odd=1 -> odd rule).
    function automatic logic parity_bad(input word_t d, input logic pbit,
                                        input logic odd);
        return (^d) ^ pbit ^ odd;
    endfunction

endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= {STAGES{RESET_VAL}};
        else
            chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/serrx_frame.sv
module serrx_frame
    import serrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       rx_s,
    input  logic [2:0] cfg_len,
    input  logic [1:0] cfg_parity,
    output logic       word_valid,
    output entry_t     word_out
);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OS_RATE - 1);
    localparam logic [CNT_W-1:0] MID_CNT   = CNT_W'(MID_TICK - 1);

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    word_t            shreg;
    logic             perr_q;
    logic             par_on;
    logic             par_odd;

    assign par_on  = cfg_parity[1];
    assign par_odd = cfg_parity[0];

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            perr_q <= 1'b0;
        end else if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (!rx_s) begin
                        state <= ST_START;
                        cnt   <= CNT_W'(1);
                    end
                end
                ST_START: begin
                    if (cnt == MID_CNT) begin
                        cnt <= '0;
                        if (!rx_s) begin
                            state  <= ST_DATA;
                            idx    <= '0;
                            shreg  <= '0;
                            perr_q <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == LAST_TICK) begin
                        cnt        <= '0;
                        shreg[idx] <= rx_s;
                        idx        <= idx + 1'b1;
                        if (idx == last_index(cfg_len))
                            state <= par_on ? ST_PAR : ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (cnt == LAST_TICK) begin
                        cnt    <= '0;
                        perr_q <= parity_bad(shreg, rx_s, par_odd);
                        state  <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt == LAST_TICK) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign word_valid    = en && tick && (state == ST_STOP) && (cnt == LAST_TICK);
    assign word_out.data = shreg;
    assign word_out.ferr = !rx_s;
    assign word_out.perr = perr_q;
endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo
    import serrx_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  entry_t        push_data,
    input  logic          pop,
    output entry_t        head,
    output logic          not_empty,
    output logic          pop_ok,
    output logic          drop,
    output logic [CW-1:0] count
);
    entry_t        mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic          push_ok;

    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign not_empty = (count != '0);
    assign pop_ok    = pop && not_empty;
    assign push_ok   = push && ((count != CW'(DEPTH)) || pop_ok);
    assign drop      = push && !push_ok;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= next_ptr(wr_ptr);
            end
            if (pop_ok)
                rd_ptr <= next_ptr(rd_ptr);
            if (push_ok && !pop_ok)
                count <= count + 1'b1;
            else if (pop_ok && !push_ok)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/serrx_top.sv
module serrx_top
    import serrx_pkg::*;
#(
    parameter int FIFO_DEPTH = Q_DEPTH,
    parameter int SYNC_STAGES = 2,
    localparam int QCW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                os_tick,
    input  logic                rx_line,
    input  logic                cfg_enable,
    input  logic [2:0]          cfg_len,
    input  logic [1:0]          cfg_parity,
    input  logic                rd_pop,
    output logic                rx_done,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                st_frame_err,
    output logic                st_parity_err,
    output logic                st_overrun
);
    logic           rx_s;
    logic           frm_valid;
    entry_t         frm_word;
    entry_t         q_head;
    logic           q_not_empty;
    logic           q_pop_ok;
    logic           q_drop;
    logic [QCW-1:0] q_count;
    logic           ovr_q;

    serrx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (rx_line),
        .d_out (rx_s)
    );

    serrx_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_enable),
        .tick       (os_tick),
        .rx_s       (rx_s),
        .cfg_len    (cfg_len),
        .cfg_parity (cfg_parity),
        .word_valid (frm_valid),
        .word_out   (frm_word)
    );

    serrx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (!cfg_enable),
        .push      (frm_valid),
        .push_data (frm_word),
        .pop       (rd_pop),
        .head      (q_head),
        .not_empty (q_not_empty),
        .pop_ok    (q_pop_ok),
        .drop      (q_drop),
        .count     (q_count)
    );

    always_ff @(posedge clk) begin
        if (rst || !cfg_enable)
            ovr_q <= 1'b0;
        else if (q_drop)
            ovr_q <= 1'b1;
        else if (q_pop_ok)
            ovr_q <= 1'b0;
    end

    assign rx_done       = q_not_empty;
    assign rx_data       = q_not_empty ? q_head.data : '0;
    assign st_frame_err  = q_not_empty && q_head.ferr;
    assign st_parity_err = q_not_empty && q_head.perr;
    assign st_overrun    = ovr_q;
endmodule

// File: rtl/serrx_chk.sv
module serrx_chk #(
    parameter int DEPTH = 2,
    parameter int QW    = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_enable,
    input logic          rd_pop,
    input logic          rx_done,
    input logic          st_overrun,
    input logic          word_valid,
    input logic [QW-1:0] q_count
);
    // R10
    disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> (!rx_done && !st_overrun));

    // R9
    overrun_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_overrun) |-> rx_done);

    // R9
    full_drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && word_valid && q_count == QW'(DEPTH) && !rd_pop) |=> st_overrun);

    // R4
    done_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && !rd_pop && !word_valid) |=> $stable(rx_done));

    // R4
    last_pop_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && rd_pop && q_count == QW'(1) && !word_valid) |=> !rx_done);

    // R5
    full_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && q_count == QW'(DEPTH) && !rd_pop) |=> (q_count == QW'(DEPTH)));
endmodule

bind serrx_top serrx_chk #(.DEPTH(FIFO_DEPTH), .QW(QCW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_enable (cfg_enable),
    .rd_pop     (rd_pop),
    .rx_done    (rx_done),
    .st_overrun (st_overrun),
    .word_valid (frm_valid),
    .q_count    (q_count)
);

// File: tb/test_serrx_top.sv
module test_serrx_top;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 4;
    localparam int BITCLK     = 16 * TDIV;

    typedef struct {
        logic [8:0] data;
        logic       ferr;
        logic       perr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick;
    logic       rx_line = 1'b1;
    logic       cfg_enable = 1'b0;
    logic [2:0] cfg_len = 3'd3;
    logic [1:0] cfg_parity = 2'b00;
    logic       rd_pop = 1'b0;
    logic       rx_done;
    logic [8:0] rx_data;
    logic       st_frame_err;
    logic       st_parity_err;
    logic       st_overrun;

    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;
    int   tcnt = 0;
    exp_t expq[$];
    bit   exp_ovr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    assign os_tick = (tcnt == TDIV - 1);

    serrx_top i_serrx_top (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line),
        .cfg_enable(cfg_enable), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
        .rd_pop(rd_pop), .rx_done(rx_done), .rx_data(rx_data),
        .st_frame_err(st_frame_err), .st_parity_err(st_parity_err),
        .st_overrun(st_overrun)
    );

    function automatic int nbits(input logic [2:0] code);
        return (code > 3'd4) ? 9 : int'(code) + 5;
    endfunction

    function automatic logic [8:0] mask_data(input logic [8:0] d, input int n);
        return d & ((9'h1 << n) - 9'h1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_bits(input int ticks);
        repeat (ticks * TDIV) @(negedge clk);
    endtask

    // Send one frame; bad_stop makes the stop bit low for 10 of its 16 ticks.
    task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_stop);
        int n = nbits(cfg_len);
        logic [8:0] m = mask_data(d, n);
        logic p = (^m) ^ cfg_parity[0] ^ bad_par;
        rx_line = 1'b0; hold_bits(16);
        for (int i = 0; i < n; i++) begin
            rx_line = m[i]; hold_bits(16);
        end
        if (cfg_parity[1]) begin
            rx_line = p; hold_bits(16);
        end
        if (bad_stop) begin
            rx_line = 1'b0; hold_bits(10);
            rx_line = 1'b1; hold_bits(6);
        end else begin
            rx_line = 1'b1; hold_bits(16);
        end
        hold_bits(32);
        begin
            exp_t e;
            e.data = m;
            e.ferr = bad_stop;
            e.perr = cfg_parity[1] && bad_par;
            if (expq.size() < 2) expq.push_back(e);
            else exp_ovr = 1;
        end
    endtask

    task automatic check_head(input string tag);
        check({tag, " rx_done"}, rx_done, expq.size() > 0);
        check({tag, " overrun"}, st_overrun, exp_ovr);
        if (expq.size() > 0) begin
            check({tag, " data"}, rx_data, expq[0].data);
            check({tag, " ferr"}, st_frame_err, expq[0].ferr);
            check({tag, " perr"}, st_parity_err, expq[0].perr);
        end
    endtask

    task automatic do_pop();
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
        if (expq.size() > 0) begin
            void'(expq.pop_front());
            exp_ovr = 0;
        end
    endtask

    task automatic drain(input string tag);
        while (expq.size() > 0) begin
            check_head(tag);
            do_pop();
        end
        check_head({tag, " empty"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1234_5A5A);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rx_done", rx_done, 0);
        check("R1 overrun", st_overrun, 0);
        check("R1 data", rx_data, 0);
        check("R1 errs", {st_frame_err, st_parity_err}, 0);
        rst = 1'b0;
        cfg_enable = 1'b1;
        hold_bits(32);

        // R2 each length, no parity, LSB first, zero-filled
        for (int l = 0; l < 6; l++) begin
            cfg_len = 3'(l); cfg_parity = 2'b00;
            send_frame(9'h1A5, 0, 0);
            drain("R2 length");
        end
        // R7 even and odd, good and bad parity; 01 means none
        for (int pm = 1; pm < 4; pm++) begin
            cfg_len = 3'd3; cfg_parity = 2'(pm);
            send_frame(9'h0B3, 0, 0);
            send_frame(9'h0B3, 1, 0);
            drain("R7 parity");
        end
        // R6 bad stop bit
        cfg_parity = 2'b10;
        send_frame(9'h05C, 0, 1);
        drain("R6 frame err");

        // R3 glitch shorter than half a bit gives nothing
        rx_line = 1'b0; hold_bits(5);
        rx_line = 1'b1; hold_bits(48);
        check("R3 glitch rx_done", rx_done, 0);

        // R5 R8 R9 three frames, third dropped, errors follow their word
        cfg_len = 3'd4; cfg_parity = 2'b11;
        send_frame(9'h155, 1, 0);
        send_frame(9'h0AA, 0, 1);
        check_head("R5 two held");
        send_frame(9'h1FF, 0, 0);
        check_head("R9 overrun");
        do_pop();
        check_head("R8 R9 after pop");
        drain("R5 order");

        // R10 disable flushes queue and overrun
        send_frame(9'h011, 0, 0);
        send_frame(9'h022, 0, 0);
        send_frame(9'h033, 0, 0);
        @(negedge clk); cfg_enable = 1'b0;
        @(negedge clk);
        check("R10 rx_done", rx_done, 0);
        check("R10 overrun", st_overrun, 0);
        expq.delete(); exp_ovr = 0;
        cfg_enable = 1'b1;
        // R10 frame in progress discarded
        rx_line = 1'b0; hold_bits(48);
        cfg_enable = 1'b0; rx_line = 1'b1; hold_bits(16);
        cfg_enable = 1'b1; hold_bits(200);
        check("R10 partial dropped", rx_done, 0);
        send_frame(9'h0C6, 0, 0);
        drain("R10 after re-enable");

        // Random frames, R2 R4 R6 R7
        for (int it = 0; it < 24; it++) begin
            int burst = 1 + int'($urandom % 3);
            cfg_len = 3'($urandom % 5);
            cfg_parity = 2'($urandom % 4);
            for (int b = 0; b < burst; b++)
                send_frame(9'($urandom), ($urandom % 5) == 0, ($urandom % 7) == 0);
            drain("R4 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule